// File: doc/BRIEF.md
# Sleep/Idle power mode controller

This block sequences the low-power states of a microcontroller core. A power-save command carries a one-bit operand. One value puts the device into Idle, where only the CPU clock is gated. The other value puts it into Sleep, where the system clock source is switched off and every clock that depends on it stops. The block turns the current mode into a set of enable outputs: CPU clock, clock-dependent peripheral clock, system clock source, clock monitor and low-power oscillator. The clock gating cells and the oscillators elsewhere on the chip act on these enables.

Any wake event brings the device back to normal execution within one cycle. A wake event is an enabled interrupt, a watchdog time-out or a reset. Each wake is reported by a one-cycle pulse that carries an encoded cause. Entry into Sleep with the watchdog enabled produces a one-cycle watchdog clear. The block also holds the request for a new system clock source. A write to the new-source field is accepted only while the clock configuration is unlocked. The request is presented to the clock switcher until it is acknowledged, and it is suspended during Sleep, so the device always resumes on the source it slept on.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted: mode_o is 0 (run), every clock enable is 1, osc_req is 0, and osc_sel and cur_src hold RESET_SRC. In the first cycle after reset is released, wake_pulse is 1 with wake_cause 3.
- R2: mode_o encodes run=0, idle=1, sleep=2. In run, with no wake event, a cycle with cmd_valid=1 changes mode_o on the next cycle to 2 if cmd_mode=1, or to 1 if cmd_mode=0. Commands in idle or sleep are ignored.
- R3: In idle, cpu_clk_en is 0 while periph_clk_en, sysclk_src_en and clkmon_en stay 1.
- R4: In sleep, cpu_clk_en, periph_clk_en, sysclk_src_en and clkmon_en are all 0.
- R5: lp_osc_en is 0 only while in sleep with wdt_enable=0. Otherwise it is 1.
- R6: wdt_clr is a one-cycle pulse in the first sleep cycle when wdt_enable was 1 with the sleep command. It never pulses on idle entry.
- R7: In idle or sleep, a pending interrupt whose enable bit is set, or wdt_timeout=1, returns mode_o to 0 on the next cycle. In that same cycle wake_pulse=1 and wake_cause is 1 for interrupt or 2 for watchdog, with the watchdog winning when both occur. A pending interrupt that is masked has no effect.
- R8: A wake event in the same cycle as a command cancels entry: the mode stays 0 and no wake_pulse is raised. A wake event in run without a command has no effect.
- R9: A cycle with osc_wr=1 and cfg_locked=0 loads osc_wdata into osc_sel and raises osc_req. The field is the 3-bit new-source field at bits 10:8 of the oscillator control word. osc_req holds until an osc_ack, which copies osc_sel into cur_src and clears osc_req. Writes with cfg_locked=1 are ignored.
- R10: During sleep, osc_req reads 0 and osc_ack is ignored, so cur_src after waking equals cur_src at sleep entry. A pending request reappears after wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Power-save command strobe |
| cmd_mode | input | 1 | Command operand: 1 sleep, 0 idle |
| irq_pending | input | N_IRQ | Interrupt request lines |
| irq_enable | input | N_IRQ | Per-line interrupt enables |
| wdt_enable | input | 1 | Watchdog is enabled |
| wdt_timeout | input | 1 | Watchdog time-out event |
| cfg_locked | input | 1 | Clock configuration lock |
| osc_wr | input | 1 | Write strobe for the new-source field |
| osc_wdata | input | SRC_W | New-source field value |
| osc_ack | input | 1 | Clock switcher has completed the switch |
| mode_o | output | 2 | Current mode |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Enable for clock-dependent peripherals |
| sysclk_src_en | output | 1 | System clock source enable |
| clkmon_en | output | 1 | Fail-safe clock monitor enable |
| lp_osc_en | output | 1 | Low-power RC oscillator enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_cause | output | 2 | Wake cause: 1 interrupt, 2 watchdog, 3 reset |
| osc_req | output | 1 | Pending clock switch request |
| osc_sel | output | SRC_W | Requested clock source |
| cur_src | output | SRC_W | Active clock source |

## Verification
The hardest state to reach is a switch acknowledge that arrives while the device sleeps with a request still pending. Two writes are needed to set it up. First the field is written under the lock, then without it, so a request is pending when the sleep command arrives. The bench then holds osc_ack high for several sleep cycles. It wakes the device by an interrupt and confirms that the source did not change and that the request comes back before it is finally acknowledged. The bench also covers a wake coinciding with the command and a reset arriving mid-sleep. A behavioural model compares all outputs every cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2
    } pm_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_IRQ  = 2'd1,
        WK_WDT  = 2'd2,
        WK_RST  = 2'd3
    } wk_cause_e;

    typedef struct packed {
        pm_state_e state;
        logic      wdt_clr;
        logic      pulse;
        wk_cause_e cause;
        logic      first;
    } fsm_regs_t;

endpackage

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb
    import pwr_mode_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_pending,
    input  logic [N_IRQ-1:0] irq_enable,
    input  logic             wdt_timeout,
    input  logic             rst_flag,
    output logic             wake_req,
    output wk_cause_e        wake_cause
);

    logic irq_hit;

    always_comb begin
        irq_hit = |(irq_pending & irq_enable);
        // priority: reset over watchdog over interrupt
        if (rst_flag)         wake_cause = WK_RST;
        else if (wdt_timeout) wake_cause = WK_WDT;
        else if (irq_hit)     wake_cause = WK_IRQ;
        else                  wake_cause = WK_NONE;
        wake_req = rst_flag | wdt_timeout | irq_hit;
    end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_valid,
    input  logic      cmd_mode,
    input  logic      wdt_enable,
    input  logic      wake_req,
    input  wk_cause_e wake_cause,
    output pm_state_e state,
    output logic      wdt_clr,
    output logic      wake_pulse,
    output wk_cause_e wake_cause_o,
    output logic      rst_flag
);

    localparam fsm_regs_t FSM_RESET = '{
        state:   PM_RUN,
        wdt_clr: 1'b0,
        pulse:   1'b0,
        cause:   WK_NONE,
        first:   1'b1
    };

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d         = fsm_q;
        fsm_d.wdt_clr = 1'b0;
        fsm_d.pulse   = 1'b0;
        fsm_d.cause   = WK_NONE;
        fsm_d.first   = 1'b0;
        case (fsm_q.state)
            PM_RUN: begin
                if (wake_req) begin
                    // a wake event blocks entry; only the reset cause is reported
                    if (fsm_q.first) begin
                        fsm_d.pulse = 1'b1;
                        fsm_d.cause = wake_cause;
                    end
                end else if (cmd_valid) begin
                    fsm_d.state   = cmd_mode ? PM_SLEEP : PM_IDLE;
                    fsm_d.wdt_clr = cmd_mode & wdt_enable;
                end
            end
            default: begin
                if (wake_req) begin
                    fsm_d.state = PM_RUN;
                    fsm_d.pulse = 1'b1;
                    fsm_d.cause = wake_cause;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= FSM_RESET;
        else        fsm_q <= fsm_d;
    end

    assign state        = fsm_q.state;
    assign wdt_clr      = fsm_q.wdt_clr;
    assign wake_pulse   = fsm_q.pulse;
    assign wake_cause_o = fsm_q.cause;
    assign rst_flag     = fsm_q.first;

    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == PM_RUN && cmd_valid && !wake_req) |=> (fsm_q.state != PM_RUN));

    assert_cmd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state != PM_RUN && !wake_req) |=> $stable(fsm_q.state));

    assert_wdt_clr_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.wdt_clr |-> (fsm_q.state == PM_SLEEP));

    assert_wake_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state != PM_RUN && wake_req) |=> (fsm_q.state == PM_RUN && fsm_q.pulse));

    assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == PM_RUN && wake_req) |=> (fsm_q.state == PM_RUN));

endmodule

// File: rtl/pwr_osc_sel.sv
module pwr_osc_sel #(
    parameter int               SRC_W     = 3,
    parameter logic [SRC_W-1:0] RESET_SRC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SRC_W-1:0] wdata,
    input  logic             locked,
    input  logic             ack,
    input  logic             asleep,
    output logic             req,
    output logic [SRC_W-1:0] nosc,
    output logic [SRC_W-1:0] cur
);

    typedef struct packed {
        logic             req;
        logic [SRC_W-1:0] nosc;
        logic [SRC_W-1:0] cur;
    } osc_regs_t;

    localparam osc_regs_t OSC_RESET = '{req: 1'b0, nosc: RESET_SRC, cur: RESET_SRC};

    osc_regs_t osc_d, osc_q;

    always_comb begin
        osc_d = osc_q;
        if (ack && !asleep && osc_q.req) begin
            osc_d.cur = osc_q.nosc;
            osc_d.req = 1'b0;
        end
        if (wr && !locked) begin
            osc_d.nosc = wdata;
            osc_d.req  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) osc_q <= OSC_RESET;
        else        osc_q <= osc_d;
    end

    assign req  = osc_q.req & ~asleep;
    assign nosc = osc_q.nosc;
    assign cur  = osc_q.cur;

    assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && locked) |=> $stable(osc_q.nosc));

    assert_hold_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> $stable(osc_q.cur));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int               N_IRQ     = 8,
    parameter int               SRC_W     = 3,
    parameter logic [SRC_W-1:0] RESET_SRC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_mode,
    input  logic [N_IRQ-1:0] irq_pending,
    input  logic [N_IRQ-1:0] irq_enable,
    input  logic             wdt_enable,
    input  logic             wdt_timeout,
    input  logic             cfg_locked,
    input  logic             osc_wr,
    input  logic [SRC_W-1:0] osc_wdata,
    input  logic             osc_ack,
    output logic [1:0]       mode_o,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             sysclk_src_en,
    output logic             clkmon_en,
    output logic             lp_osc_en,
    output logic             wdt_clr,
    output logic             wake_pulse,
    output logic [1:0]       wake_cause,
    output logic             osc_req,
    output logic [SRC_W-1:0] osc_sel,
    output logic [SRC_W-1:0] cur_src
);

    pm_state_e state;
    wk_cause_e arb_cause;
    wk_cause_e pulse_cause;
    logic      wake_req;
    logic      rst_flag;
    logic      in_sleep;

    pwr_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
        .irq_pending (irq_pending),
        .irq_enable  (irq_enable),
        .wdt_timeout (wdt_timeout),
        .rst_flag    (rst_flag),
        .wake_req    (wake_req),
        .wake_cause  (arb_cause)
    );

    pwr_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_mode     (cmd_mode),
        .wdt_enable   (wdt_enable),
        .wake_req     (wake_req),
        .wake_cause   (arb_cause),
        .state        (state),
        .wdt_clr      (wdt_clr),
        .wake_pulse   (wake_pulse),
        .wake_cause_o (pulse_cause),
        .rst_flag     (rst_flag)
    );

    assign in_sleep = (state == PM_SLEEP);

    pwr_osc_sel #(.SRC_W(SRC_W), .RESET_SRC(RESET_SRC)) u_osc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (osc_wr),
        .wdata  (osc_wdata),
        .locked (cfg_locked),
        .ack    (osc_ack),
        .asleep (in_sleep),
        .req    (osc_req),
        .nosc   (osc_sel),
        .cur    (cur_src)
    );

    always_comb begin
        mode_o        = state;
        wake_cause    = pulse_cause;
        cpu_clk_en    = (state == PM_RUN);
        periph_clk_en = !in_sleep;
        sysclk_src_en = !in_sleep;
        clkmon_en     = !in_sleep;
        lp_osc_en     = !in_sleep || wdt_enable;
    end

    assert_idle_gating_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> (!cpu_clk_en && periph_clk_en && sysclk_src_en && clkmon_en));

    assert_sleep_gating_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> !(cpu_clk_en || periph_clk_en || sysclk_src_en || clkmon_en));

    assert_pulse_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (mode_o == 2'd0 && wake_cause != 2'd0));

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_mode = 1'b0;
    logic [7:0] irq_pending = '0, irq_enable = '0;
    logic       wdt_enable = 1'b0, wdt_timeout = 1'b0;
    logic       cfg_locked = 1'b0, osc_wr = 1'b0, osc_ack = 1'b0;
    logic [2:0] osc_wdata = '0;
    logic [1:0] mode_o, wake_cause;
    logic       cpu_clk_en, periph_clk_en, sysclk_src_en, clkmon_en, lp_osc_en;
    logic       wdt_clr, wake_pulse, osc_req;
    logic [2:0] osc_sel, cur_src;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .irq_pending(irq_pending), .irq_enable(irq_enable),
        .wdt_enable(wdt_enable), .wdt_timeout(wdt_timeout),
        .cfg_locked(cfg_locked), .osc_wr(osc_wr), .osc_wdata(osc_wdata), .osc_ack(osc_ack),
        .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .sysclk_src_en(sysclk_src_en), .clkmon_en(clkmon_en), .lp_osc_en(lp_osc_en),
        .wdt_clr(wdt_clr), .wake_pulse(wake_pulse), .wake_cause(wake_cause),
        .osc_req(osc_req), .osc_sel(osc_sel), .cur_src(cur_src)
    );

    // behavioural reference model
    int m_mode, m_wclr, m_pulse, m_cause, m_first, m_req, m_nosc, m_cur;
    int hit, wk, why, slp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_wclr = 0; m_pulse = 0; m_cause = 0;
            m_first = 1; m_req = 0; m_nosc = 0; m_cur = 0;
        end else begin
            hit = ((irq_pending & irq_enable) != 0) ? 1 : 0;
            wk  = (m_first != 0 || wdt_timeout || hit != 0) ? 1 : 0;
            why = (m_first != 0) ? 3 : (wdt_timeout ? 2 : (hit != 0 ? 1 : 0));
            slp = (m_mode == 2) ? 1 : 0;
            if (osc_ack && slp == 0 && m_req != 0) begin m_cur = m_nosc; m_req = 0; end
            if (osc_wr && !cfg_locked) begin m_nosc = int'(osc_wdata); m_req = 1; end
            m_wclr = 0; m_pulse = 0; m_cause = 0;
            if (m_mode == 0) begin
                if (wk != 0) begin
                    if (m_first != 0) begin m_pulse = 1; m_cause = 3; end
                end else if (cmd_valid) begin
                    m_mode = cmd_mode ? 2 : 1;
                    m_wclr = (cmd_mode && wdt_enable) ? 1 : 0;
                end
            end else if (wk != 0) begin
                m_mode = 0; m_pulse = 1; m_cause = why;
            end
            m_first = 0;
        end
    end

    task automatic chk(input string sig, input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, sig, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("mode_o",        "R2",  int'(mode_o),        m_mode);
        chk("cpu_clk_en",    "R3",  int'(cpu_clk_en),    m_mode == 0 ? 1 : 0);
        chk("periph_clk_en", "R3",  int'(periph_clk_en), m_mode != 2 ? 1 : 0);
        chk("sysclk_src_en", "R4",  int'(sysclk_src_en), m_mode != 2 ? 1 : 0);
        chk("clkmon_en",     "R4",  int'(clkmon_en),     m_mode != 2 ? 1 : 0);
        chk("lp_osc_en",     "R5",  int'(lp_osc_en),     (m_mode != 2 || wdt_enable) ? 1 : 0);
        chk("wdt_clr",       "R6",  int'(wdt_clr),       m_wclr);
        chk("wake_pulse",    "R7",  int'(wake_pulse),    m_pulse);
        chk("wake_cause",    "R7",  int'(wake_cause),    m_cause);
        chk("osc_req",       "R9",  int'(osc_req),       (m_req != 0 && m_mode != 2) ? 1 : 0);
        chk("osc_sel",       "R9",  int'(osc_sel),       m_nosc);
        chk("cur_src",       "R10", int'(cur_src),       m_cur);
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            compare_all();
        end
    endtask

    task automatic command(input logic to_sleep);
        cmd_valid = 1'b1; cmd_mode = to_sleep;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog all actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        // R1: reset values
        step(3);
        chk("mode_o", "R1", int'(mode_o), 0);
        chk("cpu_clk_en", "R1", int'(cpu_clk_en), 1);
        chk("osc_req", "R1", int'(osc_req), 0);
        chk("cur_src", "R1", int'(cur_src), 0);
        rst_n = 1'b1;
        step();
        chk("wake_pulse", "R1", int'(wake_pulse), 1);
        chk("wake_cause", "R1", int'(wake_cause), 3);
        step();

        // R2/R3: idle entry, command in idle ignored
        command(1'b0);
        chk("mode_o", "R2", int'(mode_o), 1);
        chk("periph_clk_en", "R3", int'(periph_clk_en), 1);
        command(1'b1);
        chk("mode_o", "R2", int'(mode_o), 1);
        // R7: masked interrupt has no effect, then enabled one wakes
        irq_pending = 8'h04;
        step(2);
        chk("mode_o", "R7", int'(mode_o), 1);
        irq_enable = 8'h04;
        step();
        chk("wake_cause", "R7", int'(wake_cause), 1);
        irq_pending = '0;
        step();

        // R6/R5: sleep with watchdog enabled, wake by time-out
        wdt_enable = 1'b1;
        command(1'b1);
        chk("wdt_clr", "R6", int'(wdt_clr), 1);
        chk("lp_osc_en", "R5", int'(lp_osc_en), 1);
        chk("sysclk_src_en", "R4", int'(sysclk_src_en), 0);
        step(2);
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk("wake_cause", "R7", int'(wake_cause), 2);
        step();

        // R5: sleep without watchdog, simultaneous causes: watchdog wins
        wdt_enable = 1'b0;
        command(1'b1);
        chk("lp_osc_en", "R5", int'(lp_osc_en), 0);
        irq_pending = 8'h01; irq_enable = 8'h01; wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        chk("wake_cause", "R7", int'(wake_cause), 2);

        // R8: wake with command cancels; wake in run alone does nothing
        command(1'b1);
        chk("mode_o", "R8", int'(mode_o), 0);
        chk("wake_pulse", "R8", int'(wake_pulse), 0);
        step(2);
        irq_pending = '0;
        step();

        // R9: locked write ignored, unlocked write requests, ack applies
        cfg_locked = 1'b1; osc_wr = 1'b1; osc_wdata = 3'd5;
        step();
        chk("osc_sel", "R9", int'(osc_sel), 0);
        cfg_locked = 1'b0;
        step();
        osc_wr = 1'b0;
        chk("osc_req", "R9", int'(osc_req), 1);
        // R10: pending request hidden and ack ignored in sleep
        command(1'b1);
        chk("osc_req", "R10", int'(osc_req), 0);
        osc_ack = 1'b1;
        step(3);
        osc_ack = 1'b0;
        chk("cur_src", "R10", int'(cur_src), 0);
        irq_pending = 8'h01;
        step();
        irq_pending = '0;
        chk("osc_req", "R10", int'(osc_req), 1);
        osc_ack = 1'b1;
        step();
        osc_ack = 1'b0;
        chk("cur_src", "R9", int'(cur_src), 5);
        step();
        cfg_locked = 1'b0; osc_wr = 1'b1; osc_wdata = 3'd2;
        step();
        osc_wr = 1'b0; osc_ack = 1'b1;
        step();
        osc_ack = 1'b0;
        chk("cur_src", "R9", int'(cur_src), 2);

        // R1: reset during sleep
        command(1'b1);
        rst_n = 1'b0;
        step();
        chk("mode_o", "R1", int'(mode_o), 0);
        chk("cur_src", "R1", int'(cur_src), 0);
        rst_n = 1'b1;
        step();
        chk("wake_cause", "R1", int'(wake_cause), 3);
        step(2);

        summary();
        $finish;
    end

endmodule